// File: doc/BRIEF.md
# Row-Hit-First Memory Request Scheduler

This block sits in front of the command stage of a single-channel DRAM controller. It holds pending reads and writes in two separate slot queues and offers one request at a time on a valid/ready output. Each arriving request carries a direction, rank, bank, row, starting column and a burst count. A multi-burst request is cut into single-burst entries with consecutive columns before it lands in its queue.

Two configuration inputs set the ordering. With row-hit preference off, the oldest entry always goes first. With it on and the open-page policy in force, an entry whose row is already open in its bank goes ahead of older entries that would miss. Among entries of equal hit status, the oldest goes first. Selecting the close-page policy cancels the hit preference. Every entry carries an arrival tag, so age comparison is exact.

Reads are normally served first. Once the write queue reaches a high-water count, the block switches to draining writes. Draining holds until the write count falls below a low-water count, and then reads resume. Writes are also offered whenever no read is pending.

Top module: `dram_req_sched`

## Requirements
- R1: After reset both queues are empty, `sel_valid` is 0, and `req_ready` is 1 for either direction.
- R2: With `cfg_row_hit_first` = 0, the offered request of the served direction is always the oldest queued one. This holds even after freed slots have been reused.
- R3: With `cfg_row_hit_first` = 1 and `cfg_close_page` = 0, an entry is a hit when `bank_open[i]` is 1 and `bank_row[i*ROW_W +: ROW_W]` equals its row, where i = rank*BANKS + bank. A hit is offered before any miss, and the oldest entry wins among entries of equal hit status.
- R4: With `cfg_close_page` = 1, the open-row inputs have no effect and the oldest entry is offered.
- R5: A request with `req_len` = N-1 becomes N queue entries. They keep the same rank, bank and row, take columns col, col+1, … modulo 2^COL_W, and arrive in that age order. `req_ready` stays 0 until the last entry is placed.
- R6: When a queue holds DEPTH entries, `req_ready` is 0 for requests of that direction. A request of the other direction is still accepted.
- R7: When the write count is at least ceil(DEPTH*HI_PCT/100), a write is offered even if reads are pending.
- R8: Once draining, writes stay offered while the write count is at least floor(DEPTH*LO_PCT/100) and nonzero. Below that count, pending reads are offered again.
- R9: Outside draining, reads are offered while any read is queued, and a queued write is offered when the read queue is empty. `sel_write` is 1 exactly when the offered entry comes from the write queue.
- R10: A request accepted at one clock edge is not visible at the output after that edge. It can be offered after the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_row_hit_first | input | 1 | 1 = prefer open-row hits, 0 = strict age order |
| cfg_close_page | input | 1 | 1 = close-page policy (hit preference off) |
| req_valid | input | 1 | Incoming request valid |
| req_ready | output | 1 | Incoming request accepted when high with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_rank | input | RANK_W | Target rank (clog2 RANKS, at least 1) |
| req_bank | input | BANK_W | Target bank (clog2 BANKS, at least 1) |
| req_row | input | ROW_W | Target row |
| req_col | input | COL_W | Starting column, in burst units |
| req_len | input | LEN_W | Number of bursts minus one |
| bank_open | input | RANKS*BANKS | Per-bank row-open flags, index rank*BANKS+bank |
| bank_row | input | RANKS*BANKS*ROW_W | Per-bank open row, packed by the same index |
| sel_valid | output | 1 | A request is offered |
| sel_ready | input | 1 | Command stage takes the offered request |
| sel_write | output | 1 | Offered request is a write |
| sel_rank | output | RANK_W | Offered rank |
| sel_bank | output | BANK_W | Offered bank |
| sel_row | output | ROW_W | Offered row |
| sel_col | output | COL_W | Offered column |

## Verification
The bench builds the block with DEPTH = 4, one rank, two banks, 2-bit rows, 3-bit columns and a 5-bit tag. With these values the high and low water counts become 3 and 2, so every drain transition is reached within a handful of requests. The small row and bank space lets the bench sweep all sixteen open-flag and open-row combinations under each of the three ordering modes. Several hundred arrivals wrap the 5-bit tag many times, which exercises the wrap-safe age comparison. Slot reuse after partial draining is also covered.

// File: rtl/dsched_pkg.sv
package dsched_pkg;

   typedef enum logic {
      SRC_READ  = 1'b0,
      SRC_WRITE = 1'b1
   } src_e;

   function automatic int width_of(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

   function automatic int pct_up(input int n, input int p);
      return (n * p + 99) / 100;
   endfunction

   function automatic int pct_down(input int n, input int p);
      return (n * p) / 100;
   endfunction

endpackage

// File: rtl/dsched_split.sv
module dsched_split #(
   parameter  int RANK_W = 1,
   parameter  int BANK_W = 3,
   parameter  int ROW_W  = 14,
   parameter  int COL_W  = 7,
   parameter  int LEN_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic              in_write,
   input  logic [RANK_W-1:0] in_rank,
   input  logic [BANK_W-1:0] in_bank,
   input  logic [ROW_W-1:0]  in_row,
   input  logic [COL_W-1:0]  in_col,
   input  logic [LEN_W-1:0]  in_len,
   input  logic              rd_full,
   input  logic              wr_full,
   output logic              rd_push,
   output logic              wr_push,
   output logic [RANK_W-1:0] out_rank,
   output logic [BANK_W-1:0] out_bank,
   output logic [ROW_W-1:0]  out_row,
   output logic [COL_W-1:0]  out_col
);

   logic              busy_q;
   logic              wr_q;
   logic [LEN_W-1:0]  rem_q;
   logic [RANK_W-1:0] rank_q;
   logic [BANK_W-1:0] bank_q;
   logic [ROW_W-1:0]  row_q;
   logic [COL_W-1:0]  col_q;
   logic              take;
   logic              emit;

   assign in_ready = !busy_q && !(in_write ? wr_full : rd_full);
   assign take     = in_valid && in_ready;
   assign emit     = busy_q && !(wr_q ? wr_full : rd_full);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         wr_q   <= 1'b0;
         rem_q  <= '0;
         rank_q <= '0;
         bank_q <= '0;
         row_q  <= '0;
         col_q  <= '0;
      end else if (take) begin
         busy_q <= 1'b1;
         wr_q   <= in_write;
         rem_q  <= in_len;
         rank_q <= in_rank;
         bank_q <= in_bank;
         row_q  <= in_row;
         col_q  <= in_col;
      end else if (emit) begin
         if (rem_q == '0) begin
            busy_q <= 1'b0;
         end else begin
            rem_q <= rem_q - LEN_W'(1);
            col_q <= col_q + COL_W'(1);
         end
      end
   end

   assign rd_push  = emit && !wr_q;
   assign wr_push  = emit && wr_q;
   assign out_rank = rank_q;
   assign out_bank = bank_q;
   assign out_row  = row_q;
   assign out_col  = col_q;

   assert_col_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(emit) && $past(rem_q) != '0) |-> (busy_q && out_col == $past(out_col) + COL_W'(1)))
      else $error("burst split lost a column step");

endmodule

// File: rtl/dsched_queue.sv
module dsched_queue
   import dsched_pkg::*;
#(
   parameter  int DEPTH  = 32,
   parameter  int TAG_W  = 16,
   parameter  int RANKS  = 2,
   parameter  int BANKS  = 8,
   parameter  int ROW_W  = 14,
   parameter  int COL_W  = 7,
   localparam int NB     = RANKS * BANKS,
   localparam int RANK_W = width_of(RANKS),
   localparam int BANK_W = width_of(BANKS),
   localparam int IDX_W  = width_of(NB),
   localparam int SLOT_W = width_of(DEPTH),
   localparam int CNT_W  = $clog2(DEPTH + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                push,
   input  logic [RANK_W-1:0]   push_rank,
   input  logic [BANK_W-1:0]   push_bank,
   input  logic [ROW_W-1:0]    push_row,
   input  logic [COL_W-1:0]    push_col,
   input  logic                hit_en,
   input  logic [NB-1:0]       bank_open,
   input  logic [NB*ROW_W-1:0] bank_row,
   input  logic                pop,
   output logic                head_valid,
   output logic [RANK_W-1:0]   head_rank,
   output logic [BANK_W-1:0]   head_bank,
   output logic [ROW_W-1:0]    head_row,
   output logic [COL_W-1:0]    head_col,
   output logic [CNT_W-1:0]    count,
   output logic                full
);

   localparam logic [IDX_W:0]   NB_C    = (IDX_W + 1)'(NB);
   localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

   if (TAG_W < SLOT_W + 2) begin : g_bad_tag
      $error("TAG_W too narrow for wrap-safe age compare");
   end

   logic [DEPTH-1:0]  v_q;
   logic [DEPTH-1:0]  hit;
   logic [TAG_W-1:0]  tag_q  [DEPTH];
   logic [RANK_W-1:0] rank_q [DEPTH];
   logic [BANK_W-1:0] bank_q [DEPTH];
   logic [ROW_W-1:0]  row_q  [DEPTH];
   logic [COL_W-1:0]  col_q  [DEPTH];
   logic [TAG_W-1:0]  tag_ctr_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [ROW_W-1:0]  open_row [NB];

   for (genvar b = 0; b < NB; b++) begin : g_bank
      assign open_row[b] = bank_row[b*ROW_W +: ROW_W];
   end

   for (genvar s = 0; s < DEPTH; s++) begin : g_slot
      logic [IDX_W-1:0] idx;
      logic             in_range;
      assign idx      = IDX_W'(rank_q[s]) * IDX_W'(BANKS) + IDX_W'(bank_q[s]);
      assign in_range = {1'b0, idx} < NB_C;
      assign hit[s]   = hit_en && v_q[s] && in_range && bank_open[idx]
                        && (open_row[idx] == row_q[s]);
   end

   function automatic logic older(input logic [TAG_W-1:0] a, input logic [TAG_W-1:0] b);
      logic [TAG_W-1:0] d;
      d = a - b;
      return d[TAG_W-1];
   endfunction

   logic              found;
   logic              best_hit;
   logic [TAG_W-1:0]  best_tag;
   logic [SLOT_W-1:0] best_idx;
   logic [SLOT_W-1:0] free_idx;
   logic              do_push;
   logic              do_pop;

   always_comb begin
      found    = 1'b0;
      best_hit = 1'b0;
      best_tag = '0;
      best_idx = '0;
      for (int s = 0; s < DEPTH; s++) begin
         if (v_q[s]) begin
            if (!found || (hit[s] && !best_hit)
                || (hit[s] == best_hit && older(tag_q[s], best_tag))) begin
               found    = 1'b1;
               best_hit = hit[s];
               best_tag = tag_q[s];
               best_idx = SLOT_W'(s);
            end
         end
      end
   end

   always_comb begin
      free_idx = '0;
      for (int s = DEPTH - 1; s >= 0; s--) begin
         if (!v_q[s]) free_idx = SLOT_W'(s);
      end
   end

   assign full    = (cnt_q == DEPTH_C);
   assign do_push = push && !full;
   assign do_pop  = pop && found;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         v_q       <= '0;
         tag_ctr_q <= '0;
         cnt_q     <= '0;
         for (int s = 0; s < DEPTH; s++) begin
            tag_q[s]  <= '0;
            rank_q[s] <= '0;
            bank_q[s] <= '0;
            row_q[s]  <= '0;
            col_q[s]  <= '0;
         end
      end else begin
         if (do_push) begin
            v_q[free_idx]    <= 1'b1;
            tag_q[free_idx]  <= tag_ctr_q;
            rank_q[free_idx] <= push_rank;
            bank_q[free_idx] <= push_bank;
            row_q[free_idx]  <= push_row;
            col_q[free_idx]  <= push_col;
            tag_ctr_q        <= tag_ctr_q + TAG_W'(1);
         end
         if (do_pop) begin
            v_q[best_idx] <= 1'b0;
         end
         case ({do_push, do_pop})
            2'b10:   cnt_q <= cnt_q + CNT_W'(1);
            2'b01:   cnt_q <= cnt_q - CNT_W'(1);
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   assign head_valid = found;
   assign head_rank  = rank_q[best_idx];
   assign head_bank  = bank_q[best_idx];
   assign head_row   = row_q[best_idx];
   assign head_col   = col_q[best_idx];
   assign count      = cnt_q;

   assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full)
      else $error("push into a full queue");

   assert_no_underflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> cnt_q != '0)
      else $error("pop from an empty queue");

   assert_count_tracks_R1: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q == CNT_W'($countones(v_q)))
      else $error("occupancy count out of step with slot flags");

endmodule

// File: rtl/dram_req_sched.sv
module dram_req_sched
   import dsched_pkg::*;
#(
   parameter  int DEPTH  = 32,
   parameter  int RANKS  = 2,
   parameter  int BANKS  = 8,
   parameter  int ROW_W  = 14,
   parameter  int COL_W  = 7,
   parameter  int LEN_W  = 3,
   parameter  int TAG_W  = 16,
   parameter  int HI_PCT = 70,
   parameter  int LO_PCT = 50,
   localparam int NB     = RANKS * BANKS,
   localparam int RANK_W = width_of(RANKS),
   localparam int BANK_W = width_of(BANKS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_row_hit_first,
   input  logic                cfg_close_page,
   input  logic                req_valid,
   output logic                req_ready,
   input  logic                req_write,
   input  logic [RANK_W-1:0]   req_rank,
   input  logic [BANK_W-1:0]   req_bank,
   input  logic [ROW_W-1:0]    req_row,
   input  logic [COL_W-1:0]    req_col,
   input  logic [LEN_W-1:0]    req_len,
   input  logic [NB-1:0]       bank_open,
   input  logic [NB*ROW_W-1:0] bank_row,
   output logic                sel_valid,
   input  logic                sel_ready,
   output logic                sel_write,
   output logic [RANK_W-1:0]   sel_rank,
   output logic [BANK_W-1:0]   sel_bank,
   output logic [ROW_W-1:0]    sel_row,
   output logic [COL_W-1:0]    sel_col
);

   localparam int CNT_W  = $clog2(DEPTH + 1);
   localparam int HI_CNT = pct_up(DEPTH, HI_PCT);
   localparam int LO_CNT = pct_down(DEPTH, LO_PCT);
   localparam logic [CNT_W-1:0] HI_C = CNT_W'(HI_CNT);
   localparam logic [CNT_W-1:0] LO_C = CNT_W'(LO_CNT);

   if (DEPTH < 2) begin : g_bad_depth
      $error("DEPTH must be at least 2");
   end
   if (HI_PCT < 1 || HI_PCT > 100) begin : g_bad_hi
      $error("HI_PCT must lie in 1..100");
   end
   if (LO_PCT > HI_PCT) begin : g_bad_lo
      $error("LO_PCT must not exceed HI_PCT");
   end
   if (RANKS < 1 || BANKS < 1 || ROW_W < 1 || COL_W < 1 || LEN_W < 1) begin : g_bad_geom
      $error("geometry parameters must be positive");
   end

   logic              hit_en;
   logic              rd_push, wr_push;
   logic              rd_full, wr_full;
   logic [RANK_W-1:0] s_rank;
   logic [BANK_W-1:0] s_bank;
   logic [ROW_W-1:0]  s_row;
   logic [COL_W-1:0]  s_col;

   assign hit_en = cfg_row_hit_first && !cfg_close_page;

   dsched_split #(
      .RANK_W (RANK_W),
      .BANK_W (BANK_W),
      .ROW_W  (ROW_W),
      .COL_W  (COL_W),
      .LEN_W  (LEN_W)
   ) u_split (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (req_valid),
      .in_ready (req_ready),
      .in_write (req_write),
      .in_rank  (req_rank),
      .in_bank  (req_bank),
      .in_row   (req_row),
      .in_col   (req_col),
      .in_len   (req_len),
      .rd_full  (rd_full),
      .wr_full  (wr_full),
      .rd_push  (rd_push),
      .wr_push  (wr_push),
      .out_rank (s_rank),
      .out_bank (s_bank),
      .out_row  (s_row),
      .out_col  (s_col)
   );

   logic              rd_valid, wr_valid;
   logic              rd_pop, wr_pop;
   logic [CNT_W-1:0]  rd_cnt, wr_cnt;
   logic [RANK_W-1:0] rd_rank, wr_rank;
   logic [BANK_W-1:0] rd_bank, wr_bank;
   logic [ROW_W-1:0]  rd_row, wr_row;
   logic [COL_W-1:0]  rd_col, wr_col;

   dsched_queue #(
      .DEPTH (DEPTH), .TAG_W (TAG_W), .RANKS (RANKS), .BANKS (BANKS),
      .ROW_W (ROW_W), .COL_W (COL_W)
   ) u_rdq (
      .clk        (clk),
      .rst_n      (rst_n),
      .push       (rd_push),
      .push_rank  (s_rank),
      .push_bank  (s_bank),
      .push_row   (s_row),
      .push_col   (s_col),
      .hit_en     (hit_en),
      .bank_open  (bank_open),
      .bank_row   (bank_row),
      .pop        (rd_pop),
      .head_valid (rd_valid),
      .head_rank  (rd_rank),
      .head_bank  (rd_bank),
      .head_row   (rd_row),
      .head_col   (rd_col),
      .count      (rd_cnt),
      .full       (rd_full)
   );

   dsched_queue #(
      .DEPTH (DEPTH), .TAG_W (TAG_W), .RANKS (RANKS), .BANKS (BANKS),
      .ROW_W (ROW_W), .COL_W (COL_W)
   ) u_wrq (
      .clk        (clk),
      .rst_n      (rst_n),
      .push       (wr_push),
      .push_rank  (s_rank),
      .push_bank  (s_bank),
      .push_row   (s_row),
      .push_col   (s_col),
      .hit_en     (hit_en),
      .bank_open  (bank_open),
      .bank_row   (bank_row),
      .pop        (wr_pop),
      .head_valid (wr_valid),
      .head_rank  (wr_rank),
      .head_bank  (wr_bank),
      .head_row   (wr_row),
      .head_col   (wr_col),
      .count      (wr_cnt),
      .full       (wr_full)
   );

   logic drain_q;
   logic drain_now;
   src_e serve;

   always_comb begin
      if (drain_q) drain_now = (wr_cnt >= LO_C) && (wr_cnt != '0);
      else         drain_now = (wr_cnt >= HI_C);
      serve = (wr_valid && (drain_now || !rd_valid)) ? SRC_WRITE : SRC_READ;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) drain_q <= 1'b0;
      else        drain_q <= drain_now;
   end

   assign sel_valid = rd_valid || wr_valid;
   assign sel_write = (serve == SRC_WRITE);
   assign sel_rank  = sel_write ? wr_rank : rd_rank;
   assign sel_bank  = sel_write ? wr_bank : rd_bank;
   assign sel_row   = sel_write ? wr_row  : rd_row;
   assign sel_col   = sel_write ? wr_col  : rd_col;
   assign rd_pop    = sel_valid && sel_ready && !sel_write;
   assign wr_pop    = sel_valid && sel_ready && sel_write;

   assert_drain_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(drain_q) |-> $past(wr_cnt) >= HI_C)
      else $error("write drain began below the high-water count");

   assert_read_blocked_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_valid && !sel_write) |-> wr_cnt < HI_C)
      else $error("read offered with write queue at high water");

   assert_drain_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_valid && sel_write && rd_cnt != '0) |-> wr_cnt >= LO_C)
      else $error("write offered over reads below the low-water count");

endmodule

// File: tb/dram_req_sched_test.sv
`timescale 1ns/1ps
module dram_req_sched_test;

   localparam int DEPTH = 4, RANKS = 1, BANKS = 2, ROW_W = 2, COL_W = 3;
   localparam int LEN_W = 2, TAG_W = 5, HI_PCT = 70, LO_PCT = 50;
   localparam int NB = RANKS * BANKS;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic             cfg_row_hit_first = 1'b0, cfg_close_page = 1'b0;
   logic             req_valid = 1'b0, req_write = 1'b0;
   logic             req_ready;
   logic [0:0]       req_rank = '0, req_bank = '0;
   logic [1:0]       req_row = '0, req_len = '0;
   logic [2:0]       req_col = '0;
   logic [NB-1:0]    bank_open = '0;
   logic [NB*ROW_W-1:0] bank_row = '0;
   logic             sel_valid, sel_write, sel_ready = 1'b0;
   logic [0:0]       sel_rank, sel_bank;
   logic [1:0]       sel_row;
   logic [2:0]       sel_col;

   dram_req_sched #(
      .DEPTH (DEPTH), .RANKS (RANKS), .BANKS (BANKS), .ROW_W (ROW_W), .COL_W (COL_W),
      .LEN_W (LEN_W), .TAG_W (TAG_W), .HI_PCT (HI_PCT), .LO_PCT (LO_PCT)
   ) uut (
      .clk (clk), .rst_n (rst_n),
      .cfg_row_hit_first (cfg_row_hit_first), .cfg_close_page (cfg_close_page),
      .req_valid (req_valid), .req_ready (req_ready), .req_write (req_write),
      .req_rank (req_rank), .req_bank (req_bank), .req_row (req_row),
      .req_col (req_col), .req_len (req_len),
      .bank_open (bank_open), .bank_row (bank_row),
      .sel_valid (sel_valid), .sel_ready (sel_ready), .sel_write (sel_write),
      .sel_rank (sel_rank), .sel_bank (sel_bank), .sel_row (sel_row), .sel_col (sel_col)
   );

   int n_cmp = 0;
   int n_bad = 0;

   task automatic chk(input string rq, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
      end
   endtask

   // reference model of the read queue
   int m_row[16], m_bank[16], m_col[16], m_age[16];
   bit m_v[16];
   int m_next = 0;
   bit m_hit = 1'b0;
   int m_pat = 0;

   task automatic m_clear();
      for (int i = 0; i < 16; i++) m_v[i] = 1'b0;
   endtask

   task automatic m_add(input int b, input int r, input int c, input int len);
      for (int k = 0; k <= len; k++) begin
         for (int s = 0; s < 16; s++) begin
            if (!m_v[s]) begin
               m_v[s] = 1'b1; m_bank[s] = b; m_row[s] = r;
               m_col[s] = (c + k) % 8; m_age[s] = m_next;
               m_next++;
               break;
            end
         end
      end
   endtask

   function automatic bit m_is_hit(input int s);
      int orow;
      bit oflag;
      oflag = ((m_pat >> m_bank[s]) & 1) != 0;
      orow  = (m_bank[s] == 0) ? ((m_pat >> 2) & 3) : (((m_pat >> 2) + 1) & 3);
      return m_hit && oflag && (orow == m_row[s]);
   endfunction

   function automatic int m_pick();
      int best = -1;
      bit bh = 1'b0;
      for (int s = 0; s < 16; s++) begin
         if (m_v[s]) begin
            bit h = m_is_hit(s);
            if (best < 0 || (h && !bh) || (h == bh && m_age[s] < m_age[best])) begin
               best = s; bh = h;
            end
         end
      end
      return best;
   endfunction

   task automatic push(input bit w, input int b, input int r, input int c, input int len);
      int n = 0;
      @(negedge clk);
      req_valid = 1'b1; req_write = w; req_bank = 1'(b); req_row = 2'(r);
      req_col = 3'(c); req_len = 2'(len);
      #1;
      while (!req_ready && n < 50) begin
         @(negedge clk); #1; n++;
      end
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      if (!w) m_add(b, r, c, len);
      repeat (len + 1) @(negedge clk);
   endtask

   task automatic pop_model(input string rq);
      int j = m_pick();
      chk(rq, int'(sel_valid), 1);
      chk(rq, int'(sel_write), 0);
      if (j >= 0) begin
         chk(rq, int'(sel_bank) * 32 + int'(sel_row) * 8 + int'(sel_col),
             m_bank[j] * 32 + m_row[j] * 8 + m_col[j]);
         m_v[j] = 1'b0;
      end
      sel_ready = 1'b1;
      @(negedge clk);
      sel_ready = 1'b0;
   endtask

   task automatic pop_raw();
      sel_ready = 1'b1;
      @(negedge clk);
      sel_ready = 1'b0;
   endtask

   task automatic set_pattern(input int p);
      m_pat = p;
      bank_open = 2'(p & 3);
      bank_row  = {2'(((p >> 2) + 1) & 3), 2'((p >> 2) & 3)};
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin : main
      m_clear();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      chk("R1 sel_valid", int'(sel_valid), 0);
      req_write = 1'b0; #1;
      chk("R1 ready read", int'(req_ready), 1);
      req_write = 1'b1; #1;
      chk("R1 ready write", int'(req_ready), 1);

      // R10: two-edge entry latency
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0; req_bank = 1'b0; req_row = 2'd1;
      req_col = 3'd2; req_len = 2'd0;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      chk("R10 not yet visible", int'(sel_valid), 0);
      @(negedge clk);
      chk("R10 visible", int'(sel_valid), 1);
      m_add(0, 1, 2, 0);
      pop_model("R10");

      // R2 / R3 / R4: sweep over modes and open-row patterns
      for (int mode = 0; mode < 3; mode++) begin
         string rq;
         cfg_row_hit_first = (mode != 0);
         cfg_close_page    = (mode == 2);
         m_hit = (mode == 1);
         rq = (mode == 0) ? "R2 age order" : (mode == 1) ? "R3 hit first" : "R4 close page";
         for (int p = 0; p < 16; p++) begin
            set_pattern(p);
            for (int k = 0; k < 3; k++) push(1'b0, k % 2, (k + p) % 4, k, 0);
            pop_model(rq);
            for (int k = 3; k < 5; k++) push(1'b0, k % 2, (k + p) % 4, k, 0);
            for (int k = 0; k < 4; k++) pop_model(rq);
            chk({rq, " empty"}, int'(sel_valid), 0);
         end
      end

      // R5: burst split with column wrap
      cfg_row_hit_first = 1'b0; cfg_close_page = 1'b0; m_hit = 1'b0;
      set_pattern(0);
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0; req_bank = 1'b1; req_row = 2'd2;
      req_col = 3'd6; req_len = 2'd3;
      @(posedge clk);
      @(negedge clk);
      #1;
      chk("R5 ready low while splitting (read)", int'(req_ready), 0);
      req_write = 1'b1; #1;
      chk("R5 ready low while splitting (write)", int'(req_ready), 0);
      req_valid = 1'b0;
      m_add(1, 2, 6, 3);
      repeat (4) @(negedge clk);
      for (int k = 0; k < 4; k++) pop_model("R5 split order");
      chk("R5 empty", int'(sel_valid), 0);

      // R6: full read queue blocks reads only
      for (int k = 0; k < 4; k++) push(1'b0, 0, k, k, 0);
      req_write = 1'b0; #1;
      chk("R6 read refused when full", int'(req_ready), 0);
      req_write = 1'b1; #1;
      chk("R6 write still accepted", int'(req_ready), 1);
      for (int k = 0; k < 4; k++) pop_model("R6 drain");

      // R7 / R8 / R9: write drain hysteresis (high 3, low 2)
      m_clear();
      push(1'b0, 0, 0, 0, 0);
      push(1'b1, 0, 1, 1, 0);
      push(1'b1, 0, 1, 2, 0);
      chk("R9 read first", int'(sel_write), 0);
      chk("R9 read col", int'(sel_col), 0);
      push(1'b1, 1, 1, 3, 0);
      chk("R7 drain starts", int'(sel_write), 1);
      chk("R7 oldest write", int'(sel_col), 1);
      pop_raw();
      chk("R8 drain holds", int'(sel_write), 1);
      chk("R8 next write", int'(sel_col), 2);
      pop_raw();
      chk("R8 reads resume", int'(sel_write), 0);
      chk("R8 read col", int'(sel_col), 0);
      pop_raw();
      chk("R9 write when no reads", int'(sel_write), 1);
      chk("R9 write col", int'(sel_col), 3);
      pop_raw();
      chk("R9 all empty", int'(sel_valid), 0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule